// File: doc/BRIEF.md
# Single-Clock FIFO with Adjustable Near-Empty and Near-Full Flags

This block is a synchronous first-in first-out queue whose storage is a fixed array of 9216 bits. A build parameter picks the word width as 36, 18 or 9 bits. The depth follows from the width: 256, 512 or 1024 words. Writes and reads share one clock. Every storage location can hold data, because the queue keeps an occupancy count instead of reserving a spare slot to tell full from empty.

Four status flags are produced: empty, near-empty, full and near-full. Near-empty is measured upward from the empty end, and near-full is measured downward from the full end. Each of the two thresholds has its own build parameter that selects its source. The source is either a fixed build value or a live input port, and a port threshold takes effect in the same cycle that it changes. A write while full and a read while empty are dropped, and each is reported by a one-cycle pulse. The read data path is built either registered or unregistered.

Top module: `pflag_fifo`

## Requirements
- R1: The depth is 9216 / DATA_W words: 256 for width 36, 512 for width 18 and 1024 for width 9. `full` rises only after exactly DEPTH words are stored. `empty` and `full` are never high together.
- R2: After synchronous reset the FIFO holds no words. `empty` and `part_empty` are 1. `full`, `overflow` and `underflow` are 0. `part_full` is 0 when the full threshold is below DEPTH. `rd_data` is 0 in registered mode.
- R3: A write request while `full` is 1 stores nothing. `overflow` is 1 for the single cycle after that request.
- R4: A read request while `empty` is 1 removes nothing. `underflow` is 1 for the single cycle after that request.
- R5: Words come out in the order they were written.
- R6: A read and a write in the same cycle on a FIFO that is neither empty nor full leave the occupancy unchanged. On a full FIFO the read is taken and the write is dropped. On an empty FIFO the write is taken and the read is dropped.
- R7: `part_empty` is 1 exactly when the occupancy is less than or equal to the near-empty threshold.
- R8: `part_full` is 1 exactly when the occupancy plus the near-full threshold is at least DEPTH.
- R9: When a threshold's source is the fixed value (source code 0), the matching level port has no effect. When the source is the port (source code 1), a change on that port shows on the flag in the same cycle, with no clock edge needed.
- R10: In registered mode (read path code 1), `rd_data` takes the popped word at the clock edge that accepts the read. It holds its value in every cycle without an accepted read.
- R11: In unregistered mode (read path code 0), `rd_data` always shows the oldest stored word. After a read it shows the next word with no extra cycle.
- R12: All four flags reflect the occupancy that results from the most recent clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both reads and writes |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write request |
| wr_data | input | DATA_W | Word to store |
| rd_en | input | 1 | Read request |
| rd_data | output | DATA_W | Read word (registered or unregistered, by parameter) |
| pe_level | input | log2(DEPTH)+1 | Near-empty threshold, used when its source is the port |
| pf_level | input | log2(DEPTH)+1 | Near-full threshold, used when its source is the port |
| empty | output | 1 | No words stored |
| part_empty | output | 1 | Occupancy at or below the near-empty threshold |
| full | output | 1 | DEPTH words stored |
| part_full | output | 1 | Occupancy within the near-full threshold of DEPTH |
| overflow | output | 1 | One-cycle pulse after a write request that was dropped |
| underflow | output | 1 | One-cycle pulse after a read request that was dropped |

## Verification
The 18-bit, registered-read build runs through a short table of push, pop and combined push-pop patterns. This table separates a plain pop, a balanced pop-and-push, and a combined request on an empty queue, where only the write may take effect. A full fill followed by a full drain checks the exact occupancy at which each flag turns on, whether a write is dropped at the top, and the order of all 512 words. Moving the threshold ports while the queue is nearly full tells a live threshold apart from a fixed one. A second build, 9 bits wide with an unregistered read path and the port sources swapped, confirms the head-of-queue view on `rd_data` and the 1024-word depth.

// File: rtl/pflag_fifo_pkg.sv
package pflag_fifo_pkg;

    localparam int ARRAY_BITS = 9216;

    typedef enum logic {
        RD_UNREG = 1'b0,
        RD_REGD  = 1'b1
    } rd_path_e;

    typedef enum logic {
        THR_PARAM = 1'b0,
        THR_PORT  = 1'b1
    } thr_src_e;

    typedef struct packed {
        logic empty;
        logic part_empty;
        logic full;
        logic part_full;
    } status_t;

    typedef struct packed {
        logic wr_ok;
        logic rd_ok;
    } grant_t;

    function automatic int words_for(input int width);
        return ARRAY_BITS / width;
    endfunction

    function automatic int ptr_bits(input int width);
        return $clog2(ARRAY_BITS / width);
    endfunction

endpackage

// File: rtl/fifo_occ_ctrl.sv
module fifo_occ_ctrl
    import pflag_fifo_pkg::*;
#(
    parameter int AW    = 9,
    parameter int CW    = 10,
    parameter int DEPTH = 512
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_req,
    input  logic          rd_req,
    output grant_t        grant,
    output logic [AW-1:0] wr_addr,
    output logic [AW-1:0] rd_addr,
    output logic [CW-1:0] occ,
    output logic          overflow,
    output logic          underflow
);

    localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

    logic is_empty;
    logic is_full;

    assign is_empty    = (occ == '0);
    assign is_full     = (occ == DEPTH_C);
    assign grant.wr_ok = wr_req & ~is_full;
    assign grant.rd_ok = rd_req & ~is_empty;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_addr   <= '0;
            rd_addr   <= '0;
            occ       <= '0;
            overflow  <= 1'b0;
            underflow <= 1'b0;
        end else begin
            if (grant.wr_ok) wr_addr <= wr_addr + AW'(1);
            if (grant.rd_ok) rd_addr <= rd_addr + AW'(1);
            unique case (grant)
                2'b10:   occ <= occ + CW'(1);
                2'b01:   occ <= occ - CW'(1);
                default: occ <= occ;
            endcase
            overflow  <= wr_req & is_full;
            underflow <= rd_req & is_empty;
        end
    end

endmodule

// File: rtl/fifo_store.sv
module fifo_store
    import pflag_fifo_pkg::*;
#(
    parameter int       DW      = 18,
    parameter int       AW      = 9,
    parameter rd_path_e RD_PATH = RD_REGD
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    localparam int WORDS = 2 ** AW;

    logic [DW-1:0] cells [WORDS];

    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
    end

    generate
        if (RD_PATH == RD_REGD) begin : g_reg_out
            logic [DW-1:0] out_q;
            always_ff @(posedge clk) begin
                if (rst)     out_q <= '0;
                else if (re) out_q <= cells[raddr];
            end
            assign rdata = out_q;
        end else begin : g_comb_out
            logic unused_ctl;
            assign unused_ctl = re ^ rst;
            assign rdata      = cells[raddr];
        end
    endgenerate

endmodule

// File: rtl/fifo_status.sv
module fifo_status
    import pflag_fifo_pkg::*;
#(
    parameter int       CW     = 10,
    parameter int       DEPTH  = 512,
    parameter thr_src_e PE_SRC = THR_PARAM,
    parameter thr_src_e PF_SRC = THR_PORT,
    parameter int       PE_FIX = 2,
    parameter int       PF_FIX = 3
) (
    input  logic [CW-1:0] occ,
    input  logic [CW-1:0] pe_port,
    input  logic [CW-1:0] pf_port,
    output status_t       st
);

    localparam logic [CW:0] DEPTH_W = (CW+1)'(DEPTH);

    logic [CW-1:0] pe_thr;
    logic [CW-1:0] pf_thr;
    logic [CW:0]   pf_sum;

    generate
        if (PE_SRC == THR_PORT) begin : g_pe_port
            assign pe_thr = pe_port;
        end else begin : g_pe_fix
            logic [CW-1:0] unused_pe;
            assign unused_pe = pe_port;
            assign pe_thr    = CW'(PE_FIX);
        end

        if (PF_SRC == THR_PORT) begin : g_pf_port
            assign pf_thr = pf_port;
        end else begin : g_pf_fix
            logic [CW-1:0] unused_pf;
            assign unused_pf = pf_port;
            assign pf_thr    = CW'(PF_FIX);
        end
    endgenerate

    assign pf_sum        = {1'b0, occ} + {1'b0, pf_thr};
    assign st.empty      = (occ == '0);
    assign st.full       = ({1'b0, occ} == DEPTH_W);
    assign st.part_empty = (occ <= pe_thr);
    assign st.part_full  = (pf_sum >= DEPTH_W);

endmodule

// File: rtl/pflag_fifo.sv
module pflag_fifo
    import pflag_fifo_pkg::*;
#(
    parameter int       DATA_W  = 18,
    parameter rd_path_e RD_PATH = RD_REGD,
    parameter thr_src_e PE_SRC  = THR_PARAM,
    parameter thr_src_e PF_SRC  = THR_PORT,
    parameter int       PE_FIX  = 2,
    parameter int       PF_FIX  = 3,
    localparam int      DEPTH   = words_for(DATA_W),
    localparam int      AW      = ptr_bits(DATA_W),
    localparam int      CW      = AW + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    input  logic [CW-1:0]     pe_level,
    input  logic [CW-1:0]     pf_level,
    output logic              empty,
    output logic              part_empty,
    output logic              full,
    output logic              part_full,
    output logic              overflow,
    output logic              underflow
);

    grant_t        grant;
    logic [AW-1:0] wr_addr;
    logic [AW-1:0] rd_addr;
    logic [CW-1:0] occ;
    status_t       st;

    fifo_occ_ctrl #(
        .AW    (AW),
        .CW    (CW),
        .DEPTH (DEPTH)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .wr_req    (wr_en),
        .rd_req    (rd_en),
        .grant     (grant),
        .wr_addr   (wr_addr),
        .rd_addr   (rd_addr),
        .occ       (occ),
        .overflow  (overflow),
        .underflow (underflow)
    );

    fifo_store #(
        .DW      (DATA_W),
        .AW      (AW),
        .RD_PATH (RD_PATH)
    ) u_store (
        .clk   (clk),
        .rst   (rst),
        .we    (grant.wr_ok),
        .waddr (wr_addr),
        .wdata (wr_data),
        .re    (grant.rd_ok),
        .raddr (rd_addr),
        .rdata (rd_data)
    );

    fifo_status #(
        .CW     (CW),
        .DEPTH  (DEPTH),
        .PE_SRC (PE_SRC),
        .PF_SRC (PF_SRC),
        .PE_FIX (PE_FIX),
        .PF_FIX (PF_FIX)
    ) u_status (
        .occ     (occ),
        .pe_port (pe_level),
        .pf_port (pf_level),
        .st      (st)
    );

    assign empty      = st.empty;
    assign part_empty = st.part_empty;
    assign full       = st.full;
    assign part_full  = st.part_full;

endmodule

// File: rtl/pflag_fifo_chk.sv
module pflag_fifo_chk #(
    parameter int DEPTH = 512,
    parameter int CW    = 10
) (
    input logic          clk,
    input logic          rst,
    input logic          wr_en,
    input logic          rd_en,
    input logic          empty,
    input logic          full,
    input logic          part_empty,
    input logic          part_full,
    input logic          overflow,
    input logic          underflow,
    input logic [CW-1:0] occ
);

    assert_occ_bounded_R1: assert property (@(posedge clk) disable iff (rst)
        occ <= CW'(DEPTH));

    assert_not_both_R1: assert property (@(posedge clk) disable iff (rst)
        !(empty && full));

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
        wr_en && full |=> overflow);

    assert_ovf_cause_R3: assert property (@(posedge clk) disable iff (rst)
        overflow |-> $past(wr_en && full));

    assert_no_underflow_R4: assert property (@(posedge clk) disable iff (rst)
        rd_en && empty |=> underflow);

    assert_unf_cause_R4: assert property (@(posedge clk) disable iff (rst)
        underflow |-> $past(rd_en && empty));

    assert_balanced_R6: assert property (@(posedge clk) disable iff (rst)
        wr_en && rd_en && !empty && !full |=> $stable(occ));

    assert_empty_near_R7: assert property (@(posedge clk) disable iff (rst)
        empty |-> part_empty);

    assert_full_near_R8: assert property (@(posedge clk) disable iff (rst)
        full |-> part_full);

endmodule

bind pflag_fifo pflag_fifo_chk #(
    .DEPTH (DEPTH),
    .CW    (CW)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .rd_en      (rd_en),
    .empty      (empty),
    .full       (full),
    .part_empty (part_empty),
    .part_full  (part_full),
    .overflow   (overflow),
    .underflow  (underflow),
    .occ        (occ)
);

// File: tb/pflag_fifo_tb.sv
module pflag_fifo_tb;
    import pflag_fifo_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    // Build A: 18 bits, registered read, near-empty fixed at 2, near-full from port
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [17:0] wr_data = '0;
    logic [17:0] rd_data;
    logic [9:0]  pe_level = '0, pf_level = 10'd3;
    logic        empty, part_empty, full, part_full, overflow, underflow;

    pflag_fifo u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
        .rd_data(rd_data), .pe_level(pe_level), .pf_level(pf_level),
        .empty(empty), .part_empty(part_empty), .full(full), .part_full(part_full),
        .overflow(overflow), .underflow(underflow)
    );

    // Build B: 9 bits, unregistered read, near-empty from port, near-full fixed at 1
    logic        b_wr = 1'b0, b_rd = 1'b0;
    logic [8:0]  b_din = '0;
    logic [8:0]  b_dout;
    logic [10:0] b_pe = 11'd1, b_pf = '0;
    logic        b_empty, b_pe_f, b_full, b_pf_f, b_ovf, b_unf;

    pflag_fifo #(
        .DATA_W(9), .RD_PATH(RD_UNREG), .PE_SRC(THR_PORT), .PF_SRC(THR_PARAM),
        .PE_FIX(0), .PF_FIX(1)
    ) u_dut_b (
        .clk(clk), .rst(rst), .wr_en(b_wr), .wr_data(b_din), .rd_en(b_rd),
        .rd_data(b_dout), .pe_level(b_pe), .pf_level(b_pf),
        .empty(b_empty), .part_empty(b_pe_f), .full(b_full), .part_full(b_pf_f),
        .overflow(b_ovf), .underflow(b_unf)
    );

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    typedef struct packed {
        logic        wr;
        logic        rd;
        logic [17:0] din;
        logic [3:0]  flags;   // {empty, part_empty, full, part_full}
        logic        ovf;
        logic        unf;
        logic        chk_rd;
        logic [17:0] dout;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b1, 18'h0,   4'b1100, 1'b0, 1'b1, 1'b0, 18'h0},
        '{1'b1, 1'b0, 18'h111, 4'b0100, 1'b0, 1'b0, 1'b0, 18'h0},
        '{1'b1, 1'b0, 18'h222, 4'b0100, 1'b0, 1'b0, 1'b0, 18'h0},
        '{1'b1, 1'b0, 18'h333, 4'b0000, 1'b0, 1'b0, 1'b0, 18'h0},
        '{1'b0, 1'b1, 18'h0,   4'b0100, 1'b0, 1'b0, 1'b1, 18'h111},
        '{1'b1, 1'b1, 18'h444, 4'b0100, 1'b0, 1'b0, 1'b1, 18'h222},
        '{1'b0, 1'b1, 18'h0,   4'b0100, 1'b0, 1'b0, 1'b1, 18'h333},
        '{1'b0, 1'b1, 18'h0,   4'b1100, 1'b0, 1'b0, 1'b1, 18'h444},
        '{1'b1, 1'b1, 18'h555, 4'b0100, 1'b0, 1'b1, 1'b1, 18'h444},
        '{1'b0, 1'b1, 18'h0,   4'b1100, 1'b0, 1'b0, 1'b1, 18'h555}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input logic w, input logic r, input logic [17:0] d);
        @(negedge clk);
        wr_en = w; rd_en = r; wr_data = d;
        @(posedge clk);
        #2;
        wr_en = 1'b0; rd_en = 1'b0;
    endtask

    task automatic bcyc(input logic w, input logic r, input logic [8:0] d);
        @(negedge clk);
        b_wr = w; b_rd = r; b_din = d;
        @(posedge clk);
        #2;
        b_wr = 1'b0; b_rd = 1'b0;
    endtask

    function automatic logic [3:0] a_flags();
        return {empty, part_empty, full, part_full};
    endfunction

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #2;

        // R2: reset state of both builds
        check("R2 flags", {28'h0, a_flags()}, 32'hC);
        check("R2 ovf/unf", {30'h0, overflow, underflow}, 32'h0);
        check("R2 rd_data", {14'h0, rd_data}, 32'h0);
        check("R2 build B flags", {28'h0, b_empty, b_pe_f, b_full, b_pf_f}, 32'hC);

        // Table: R4 R5 R6 R7 R10 R12
        for (int i = 0; i < NV; i++) begin
            cyc(VECS[i].wr, VECS[i].rd, VECS[i].din);
            check($sformatf("R7/R12 row %0d flags", i), {28'h0, a_flags()}, {28'h0, VECS[i].flags});
            check($sformatf("R4/R6 row %0d pulses", i), {30'h0, overflow, underflow},
                  {30'h0, VECS[i].ovf, VECS[i].unf});
            if (VECS[i].chk_rd)
                check($sformatf("R5/R10 row %0d rd_data", i), {14'h0, rd_data}, {14'h0, VECS[i].dout});
        end

        // Fill build A: R1 depth 512, R8 near-full with port threshold 3
        for (int k = 0; k < 512; k++) begin
            cyc(1'b1, 1'b0, 18'(k));
            if (k + 1 == 508) check("R8 below near-full", {31'h0, part_full}, 32'h0);
            if (k + 1 == 509) check("R8 near-full on", {31'h0, part_full}, 32'h1);
            if (k + 1 == 511) check("R1 not full at 511", {31'h0, full}, 32'h0);
            if (k + 1 == 512) check("R1 full at 512", {31'h0, full}, 32'h1);
        end
        check("R10 rd_data holds without read", {14'h0, rd_data}, 32'h555);

        cyc(1'b1, 1'b0, 18'h3ABC);
        check("R3 overflow pulse", {31'h0, overflow}, 32'h1);
        check("R3 still full", {31'h0, full}, 32'h1);
        cyc(1'b0, 1'b0, 18'h0);
        check("R3 pulse one cycle", {31'h0, overflow}, 32'h0);

        cyc(1'b1, 1'b1, 18'h2BAD);
        check("R6 full: read taken", {14'h0, rd_data}, 32'h0);
        check("R6 full: write dropped", {31'h0, full}, 32'h0);
        check("R3 overflow on full push-pop", {31'h0, overflow}, 32'h1);

        // R9: live near-full port, ignored near-empty port (occupancy 511)
        pf_level = 10'd0; #1;
        check("R9 pf port live low", {31'h0, part_full}, 32'h0);
        pf_level = 10'd1; #1;
        check("R9 pf port live high", {31'h0, part_full}, 32'h1);
        pf_level = 10'd3;
        pe_level = 10'd1023; #1;
        check("R9 fixed pe ignores port", {31'h0, part_empty}, 32'h0);
        pe_level = 10'd0;

        // Drain: R5 order of every word
        for (int j = 1; j < 512; j++) begin
            cyc(1'b0, 1'b1, 18'h0);
            check($sformatf("R5 word %0d", j), {14'h0, rd_data}, 32'(j));
        end
        check("R1 empty after drain", {28'h0, a_flags()}, 32'hC);
        cyc(1'b0, 1'b1, 18'h0);
        check("R4 underflow after drain", {31'h0, underflow}, 32'h1);
        check("R10 rd_data held on refused read", {14'h0, rd_data}, 32'd511);

        // Build B: R11 head view, R9 port near-empty, R1 depth 1024
        bcyc(1'b1, 1'b0, 9'h12);
        check("R11 head after first write", {23'h0, b_dout}, 32'h12);
        bcyc(1'b1, 1'b0, 9'h34);
        check("R11 head unchanged by write", {23'h0, b_dout}, 32'h12);
        check("R7 pe off above port thr", {31'h0, b_pe_f}, 32'h0);
        b_pe = 11'd2; #1;
        check("R9 pe port live", {31'h0, b_pe_f}, 32'h1);
        b_pe = 11'd1;
        bcyc(1'b0, 1'b1, 9'h0);
        check("R11 next head after read", {23'h0, b_dout}, 32'h34);
        for (int k = 1; k < 1024; k++) begin
            bcyc(1'b1, 1'b0, 9'(k));
            if (k + 1 == 1022) check("R8 B near-full off", {30'h0, b_pf_f, b_full}, 32'h0);
            if (k + 1 == 1023) check("R8 B near-full on", {30'h0, b_pf_f, b_full}, 32'h2);
            if (k + 1 == 1024) check("R1 B full at 1024", {30'h0, b_pf_f, b_full}, 32'h3);
        end
        check("R11 head still oldest", {23'h0, b_dout}, 32'h34);

        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

endmodule